// File: doc/BRIEF.md
# Banked Memory-Map Address Decoder

This block sits next to an 8-bit processor with a 16-bit address bus. It turns each bus address into one chip select for the memory or register that should answer. The targets are fixed low RAM, one 256-byte I/O page, an 8 KB banked RAM window and a 16 KB banked ROM window. Two bank-number registers also live in the first two bytes of zero page. Every select is combinational from the address, the direction line and the address-valid line, so it settles within the same bus cycle.

The first bank register drives the upper address lines of the banked RAM device. The second drives those of the ROM device. The processor writes a register by storing to its zero-page address, and the write takes effect on the next rising clock edge. A load from the same address returns the register through a read-data port, together with an output enable for the data bus. The I/O page is only selected as a whole: telling apart the devices inside it is left to logic outside this block.

Top module: `bank_map_decoder`

## Requirements
- R1: A synchronous reset sets both bank registers to 0, so `ramBank` and `romBank` read 0 after reset.
- R2: Addresses 0x0000 and 0x0001 assert `selBankReg` and never `selLowRam`. Address bit 0 picks the register: 0 is the RAM bank, 1 is the ROM bank.
- R3: Addresses 0x0002 through 0x9EFF assert `selLowRam`. This includes all of zero page above 0x0001.
- R4: Addresses 0x9F00 through 0x9FFF assert `selIo`. The match needs A15..A13 = 100 and A12..A8 all ones, so 0x1F00 and 0xDF00 do not select I/O.
- R5: Addresses 0xA000 through 0xBFFF assert `selHighRam`.
- R6: Addresses 0xC000 through 0xFFFF assert `selRom`.
- R7: While `addrValid` is 1, exactly one of the five selects is 1. While `addrValid` is 0, all five are 0.
- R8: A write (`rdWr` = 0) to 0x0000 loads `wrData` into `ramBank` at the next rising edge. A write to 0x0001 loads `romBank` the same way. A write to any other address leaves both registers unchanged.
- R9: A read (`rdWr` = 1) of 0x0000 or 0x0001 drives the selected register on `rdData` and sets `rdDataEn` in the same cycle. For any other access, `rdDataEn` is 0 and `rdData` is 0.
- R10: With `addrValid` at 0, a write to 0x0000 or 0x0001 has no effect on either register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; register writes happen on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addrValid | input | 1 | Qualifies the address and direction lines |
| addr | input | 16 | Processor address bus |
| rdWr | input | 1 | Direction: 1 for read, 0 for write |
| wrData | input | 8 | Processor write-data byte |
| selLowRam | output | 1 | Fixed low RAM chip select |
| selIo | output | 1 | I/O page chip select |
| selHighRam | output | 1 | Banked RAM window chip select |
| selRom | output | 1 | Banked ROM window chip select |
| selBankReg | output | 1 | Bank-register access (either register) |
| ramBank | output | 8 | RAM bank number for the banked RAM upper address lines |
| romBank | output | 8 | ROM bank number for the ROM upper address lines |
| rdData | output | 8 | Bank register read-back byte |
| rdDataEn | output | 1 | Enable for driving `rdData` onto the data bus |

## Verification
The address sweep is aimed at the edges between regions: 0x0001/0x0002, 0x9EFF/0x9F00, 0x9FFF/0xA000 and 0xBFFF/0xC000. Each pair checks that the cut between two targets falls on the right byte. Two near-miss addresses, 0x1F00 and 0xDF00, have A12..A8 all ones but the wrong upper region. They show whether the I/O decode really needs both conditions or only the page bits. Writes with distinct byte patterns go to each register, to 0x0002 and with `addrValid` low. Read-back then tells apart a correct store, a swapped register index, a missing address qualifier and a missing valid qualifier.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;
  parameter int ADDR_W = 16;
  parameter int DATA_W = 8;
  parameter int WIN_BITS = 13;
  parameter int PAGE_BITS = 8;
  parameter int NUM_BANK_REGS = 2;

  localparam int REGION_W = ADDR_W - WIN_BITS;
  localparam int SUBPAGE_W = WIN_BITS - PAGE_BITS;
  localparam int REG_IDX_W = $clog2(NUM_BANK_REGS);

  typedef struct packed {
    logic                 wrEn;
    logic                 rdEn;
    logic [REG_IDX_W-1:0] regIdx;
  } bank_strobe_t;
endpackage

// File: rtl/bank_map_ctrl.sv
module bank_map_ctrl
  import bank_map_pkg::*;
(
  input  logic              addrValid,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdWr,
  output logic              selLowRam,
  output logic              selIo,
  output logic              selHighRam,
  output logic              selRom,
  output logic              selBankReg,
  output bank_strobe_t      strobe
);
  localparam logic [REGION_W-1:0] IO_REGION  = REGION_W'(3'b100);
  localparam logic [REGION_W-1:0] HRAM_REGION = REGION_W'(3'b101);

  logic [REGION_W-1:0] region;
  logic                zeroHigh;
  logic                ioMatch;
  logic                romMatch;
  logic                hramMatch;

  always_comb begin
    region    = addr[ADDR_W-1:WIN_BITS];
    zeroHigh  = (addr[ADDR_W-1:REG_IDX_W] == '0);
    ioMatch   = (region == IO_REGION) && (&addr[WIN_BITS-1:PAGE_BITS]);
    romMatch  = (region[REGION_W-1:REGION_W-2] == 2'b11);
    hramMatch = (region == HRAM_REGION);

    selBankReg = addrValid && zeroHigh;
    selIo      = addrValid && ioMatch;
    selRom     = addrValid && romMatch;
    selHighRam = addrValid && hramMatch;
    selLowRam  = addrValid && !zeroHigh && !ioMatch && !romMatch && !hramMatch;

    strobe.wrEn   = selBankReg && !rdWr;
    strobe.rdEn   = selBankReg && rdWr;
    strobe.regIdx = addr[REG_IDX_W-1:0];
  end
endmodule

// File: rtl/bank_map_regs.sv
module bank_map_regs
  import bank_map_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  bank_strobe_t      strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] ramBank,
  output logic [DATA_W-1:0] romBank,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDataEn
);
  logic [DATA_W-1:0] bankRegs [NUM_BANK_REGS];

  for (genvar gi = 0; gi < NUM_BANK_REGS; gi++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        bankRegs[gi] <= '0;
      end else if (strobe.wrEn && (strobe.regIdx == REG_IDX_W'(gi))) begin
        bankRegs[gi] <= wrData;
      end
    end
  end

  always_comb begin
    ramBank  = bankRegs[0];
    romBank  = bankRegs[1];
    rdDataEn = strobe.rdEn;
    rdData   = strobe.rdEn ? bankRegs[strobe.regIdx] : '0;
  end
endmodule

// File: rtl/bank_map_decoder.sv
module bank_map_decoder
  import bank_map_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              addrValid,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdWr,
  input  logic [DATA_W-1:0] wrData,
  output logic              selLowRam,
  output logic              selIo,
  output logic              selHighRam,
  output logic              selRom,
  output logic              selBankReg,
  output logic [DATA_W-1:0] ramBank,
  output logic [DATA_W-1:0] romBank,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDataEn
);
  bank_strobe_t strobe;

  bank_map_ctrl i_ctrl (
    .addrValid (addrValid),
    .addr      (addr),
    .rdWr      (rdWr),
    .selLowRam (selLowRam),
    .selIo     (selIo),
    .selHighRam(selHighRam),
    .selRom    (selRom),
    .selBankReg(selBankReg),
    .strobe    (strobe)
  );

  bank_map_regs i_regs (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .wrData  (wrData),
    .ramBank (ramBank),
    .romBank (romBank),
    .rdData  (rdData),
    .rdDataEn(rdDataEn)
  );
endmodule

// File: rtl/bank_map_checker.sv
module bank_map_checker
  import bank_map_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              addrValid,
  input logic [ADDR_W-1:0] addr,
  input logic              rdWr,
  input logic [DATA_W-1:0] wrData,
  input logic              selLowRam,
  input logic              selIo,
  input logic              selHighRam,
  input logic              selRom,
  input logic              selBankReg,
  input logic [DATA_W-1:0] ramBank,
  input logic [DATA_W-1:0] romBank,
  input logic [DATA_W-1:0] rdData,
  input logic              rdDataEn
);
  logic [4:0] selVec;
  assign selVec = {selLowRam, selIo, selHighRam, selRom, selBankReg};

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) && !rst |-> (ramBank == '0) && (romBank == '0));

  p_zp_claim_r2: assert property (@(posedge clk) disable iff (rst)
    addrValid && (addr < 16'h0002) |-> selBankReg && !selLowRam);

  p_io_page_r4: assert property (@(posedge clk) disable iff (rst)
    addrValid && (addr >= 16'h9F00) && (addr < 16'hA000) |-> selIo);

  p_rom_win_r6: assert property (@(posedge clk) disable iff (rst)
    addrValid && (addr >= 16'hC000) |-> selRom);

  p_one_sel_r7: assert property (@(posedge clk) disable iff (rst)
    addrValid |-> $countones(selVec) == 1);

  p_idle_sel_r7: assert property (@(posedge clk) disable iff (rst)
    !addrValid |-> selVec == '0);

  p_ram_wr_r8: assert property (@(posedge clk) disable iff (rst)
    addrValid && !rdWr && (addr == 16'h0000) |=> ramBank == $past(wrData));

  p_rom_wr_r8: assert property (@(posedge clk) disable iff (rst)
    addrValid && !rdWr && (addr == 16'h0001) |=> romBank == $past(wrData));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !(addrValid && !rdWr && (addr < 16'h0002)) |=> $stable(ramBank) && $stable(romBank));

  p_readback_r9: assert property (@(posedge clk) disable iff (rst)
    rdDataEn |-> rdData == (addr[0] ? romBank : ramBank));

  p_no_drive_r9: assert property (@(posedge clk) disable iff (rst)
    !rdDataEn |-> rdData == '0);
endmodule

bind bank_map_decoder bank_map_checker i_checker (.*);

// File: tb/test_bank_map_decoder.sv
module test_bank_map_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        addrValid = 1'b0;
  logic [15:0] addr = '0;
  logic        rdWr = 1'b1;
  logic [7:0]  wrData = '0;
  logic selLowRam, selIo, selHighRam, selRom, selBankReg, rdDataEn;
  logic [7:0] ramBank, romBank, rdData;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  bank_map_decoder i_bank_map_decoder (.*);

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [4:0] expSel(input logic [15:0] a);
    if (a < 16'h0002)      return 5'b00001;
    else if (a < 16'h9F00) return 5'b10000;
    else if (a < 16'hA000) return 5'b01000;
    else if (a < 16'hC000) return 5'b00100;
    else                   return 5'b00010;
  endfunction

  function automatic logic [4:0] gotSel();
    return {selLowRam, selIo, selHighRam, selRom, selBankReg};
  endfunction

  task automatic busOp(input logic [15:0] a, input logic rw, input logic v, input logic [7:0] d);
    @(negedge clk);
    addr = a; rdWr = rw; addrValid = v; wrData = d;
    @(posedge clk);
    #1;
    addrValid = 1'b0; rdWr = 1'b1;
  endtask

  task automatic tReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #1;
    check("R1 ramBank", {8'h0, ramBank}, 16'h0);
    check("R1 romBank", {8'h0, romBank}, 16'h0);
  endtask

  task automatic tSweep();
    logic [15:0] pts [17] = '{16'h0000, 16'h0001, 16'h0002, 16'h00FF, 16'h0100,
      16'h1F00, 16'h8000, 16'h9EFF, 16'h9F00, 16'h9F80, 16'h9FFF, 16'hA000,
      16'hBFFF, 16'hC000, 16'hDF00, 16'hE000, 16'hFFFF};
    for (int i = 0; i < 17; i++) begin
      @(negedge clk);
      addr = pts[i]; rdWr = 1'b1; addrValid = 1'b1;
      #1;
      check($sformatf("R2/R3/R4/R5/R6/R7 sel@%h", pts[i]), {11'h0, gotSel()}, {11'h0, expSel(pts[i])});
    end
    addrValid = 1'b0;
  endtask

  task automatic tInvalid();
    @(negedge clk);
    addr = 16'h9F10; addrValid = 1'b0; rdWr = 1'b1;
    #1;
    check("R7 idle sel", {11'h0, gotSel()}, 16'h0);
    addr = 16'h0000;
    #1;
    check("R9 rdDataEn idle", {15'h0, rdDataEn}, 16'h0);
  endtask

  task automatic tWriteRead();
    busOp(16'h0000, 1'b0, 1'b1, 8'h5A);
    check("R8 ramBank write", {8'h0, ramBank}, 16'h005A);
    check("R8 romBank untouched", {8'h0, romBank}, 16'h0);
    busOp(16'h0001, 1'b0, 1'b1, 8'hC3);
    check("R8 romBank write", {8'h0, romBank}, 16'h00C3);
    check("R8 ramBank kept", {8'h0, ramBank}, 16'h005A);
    @(negedge clk);
    addr = 16'h0000; rdWr = 1'b1; addrValid = 1'b1;
    #1;
    check("R9 read reg0", {7'h0, rdDataEn, rdData}, {7'h0, 1'b1, 8'h5A});
    addr = 16'h0001;
    #1;
    check("R9 read reg1", {7'h0, rdDataEn, rdData}, {7'h0, 1'b1, 8'hC3});
    addr = 16'h0002;
    #1;
    check("R9 no read outside", {7'h0, rdDataEn, rdData}, 16'h0);
    rdWr = 1'b0;
    #1;
    check("R9 no read on write", {15'h0, rdDataEn}, 16'h0);
    addrValid = 1'b0; rdWr = 1'b1;
  endtask

  task automatic tIgnored();
    busOp(16'h0002, 1'b0, 1'b1, 8'hFF);
    check("R8 write 0x0002 ram", {8'h0, ramBank}, 16'h005A);
    check("R8 write 0x0002 rom", {8'h0, romBank}, 16'h00C3);
    busOp(16'h0000, 1'b0, 1'b0, 8'h11);
    busOp(16'h0001, 1'b0, 1'b0, 8'h22);
    check("R10 invalid write ram", {8'h0, ramBank}, 16'h005A);
    check("R10 invalid write rom", {8'h0, romBank}, 16'h00C3);
    busOp(16'h0000, 1'b1, 1'b1, 8'h77);
    check("R8 read leaves ram", {8'h0, ramBank}, 16'h005A);
  endtask

  initial begin
    fork
      begin
        tReset();
        tSweep();
        tInvalid();
        tWriteRead();
        tIgnored();
        tReset();
      end
      begin
        repeat (5000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule